// File: doc/BRIEF.md
# Segmented Address Generator

This block turns a 16-bit segment base and a 16-bit pointer into a 20-bit physical memory address. It holds four segment bases (code, data, stack, extra) and five pointers (instruction, stack, frame base, string source index, string destination index). A request names an addressing source. Each source is tied to a fixed pair of one segment and one pointer. One cycle later the block presents the address, which is the segment base shifted left by four bits plus the pointer, wrapped to 20 bits.

The register load port writes any one of the nine registers per cycle. For string moves, a step command moves the source and destination indices together by 1, 2 or 4. It moves them up when the direction input is low and down when it is high.

Top module: `seg_addr_gen`

## Requirements
- R1: A request with a valid source code (0 to 4) gives `addr_valid` high one cycle later, with `addr` = (segment << 4) + pointer mod 2^20.
- R2: Source code 0 (fetch) pairs the code segment with the instruction pointer.
- R3: Source code 1 (stack) pairs the stack segment with the stack pointer.
- R4: Source code 2 (frame) pairs the stack segment with the frame base pointer.
- R5: Source code 3 (string source) pairs the data segment with the source index.
- R6: Source code 4 (string destination) pairs the extra segment with the destination index.
- R7: Synchronous reset clears every register to 0, except the code segment, which becomes 16'hFFFF. Reset also drops `addr_valid`.
- R8: A load with `ld_sel` 0..8 writes, in order, code seg, data seg, stack seg, extra seg, instruction ptr, stack ptr, frame ptr, source index, destination index. The new value is seen from the next cycle. Codes 9..15 change nothing.
- R9: A step with `dir_down`=0 adds 1, 2 or 4 (`step_size` 0, 1, 2) to both indices, wrapping at 16 bits. `step_size` 3 changes nothing.
- R10: A step with `dir_down`=1 subtracts the same amounts, wrapping at 16 bits.
- R11: When a load targets an index in the same cycle as a step, the loaded value wins for that index. The other index still steps.
- R12: A request uses register values from before any load or step in the same cycle.
- R13: A request with source code 5..7, or no request at all, leaves `addr_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 4 | Register to load (R8 codes) |
| ld_data | input | 16 | Load value |
| step_en | input | 1 | Index step strobe |
| step_size | input | 2 | Step amount code: 0=1, 1=2, 2=4, 3=none |
| dir_down | input | 1 | Step direction, 1 = decrement |
| req_valid | input | 1 | Address request |
| req_src | input | 3 | Addressing source code |
| addr_valid | output | 1 | Address output valid |
| addr | output | 20 | Physical address |

## Verification
Every source is swept over eight segment values and eight pointer values. The values include zero, the all-ones case that forces the 20-bit wrap, and the values where the shifted segment and the pointer overlap in the middle bits. This catches a wrong pairing, a wrong shift amount or a lost carry. Each step size is tried in both directions from start values next to the 16-bit wrap points, which separates the sign of the step, its amount and the no-op size code. Same-cycle load-with-step and load-with-request cases pin down the priority and the timing of visibility.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [2:0] {
    SRC_FETCH  = 3'd0,
    SRC_STACK  = 3'd1,
    SRC_FRAME  = 3'd2,
    SRC_STRSRC = 3'd3,
    SRC_STRDST = 3'd4
  } src_e;

  localparam int NUM_REGS = 9;
  localparam int SEL_W    = 4;

  localparam int RID_CODE  = 0;
  localparam int RID_DATA  = 1;
  localparam int RID_STK   = 2;
  localparam int RID_EXTRA = 3;
  localparam int RID_IP    = 4;
  localparam int RID_SP    = 5;
  localparam int RID_BP    = 6;
  localparam int RID_SI    = 7;
  localparam int RID_DI    = 8;
endpackage

// File: rtl/sag_stepper.sv
module sag_stepper #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         dec,
  input  logic [W-1:0] amt,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (dec) nxt = cur - amt;
    else     nxt = cur + amt;
  end
endmodule

// File: rtl/sag_regfile.sv
module sag_regfile
  import sag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_en,
  input  logic [SEL_W-1:0]            ld_sel,
  input  logic [W-1:0]                ld_data,
  input  logic                        step_go,
  input  logic                        step_dec,
  input  logic [W-1:0]                step_amt,
  output logic [NUM_REGS-1:0][W-1:0]  regs_o
);
  logic [NUM_REGS-1:0][W-1:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [W-1:0] RST_VAL = (i == RID_CODE) ? {W{1'b1}} : {W{1'b0}};
    logic hit;
    assign hit = ld_en && (ld_sel == SEL_W'(i));

    if (i == RID_SI || i == RID_DI) begin : g_idx
      logic [W-1:0] stepped;
      sag_stepper #(.W(W)) u_step (
        .cur(regs_q[i]), .dec(step_dec), .amt(step_amt), .nxt(stepped)
      );
      always_ff @(posedge clk) begin
        if (rst)          regs_q[i] <= RST_VAL;
        else if (hit)     regs_q[i] <= ld_data;
        else if (step_go) regs_q[i] <= stepped;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      regs_q[i] <= RST_VAL;
        else if (hit) regs_q[i] <= ld_data;
      end
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/sag_addr_calc.sv
module sag_addr_calc
  import sag_pkg::*;
#(
  parameter int W     = 16,
  parameter int SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [2:0]                  req_src,
  input  logic [NUM_REGS-1:0][W-1:0]  regs,
  output logic                        addr_valid,
  output logic [W+SHIFT-1:0]          addr
);
  localparam int ADDR_W = W + SHIFT;

  logic [W-1:0]      seg_sel, off_sel;
  logic              src_ok;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    src_ok  = 1'b1;
    seg_sel = regs[RID_CODE];
    off_sel = regs[RID_IP];
    case (src_e'(req_src))
      SRC_FETCH:  begin seg_sel = regs[RID_CODE];  off_sel = regs[RID_IP]; end
      SRC_STACK:  begin seg_sel = regs[RID_STK];   off_sel = regs[RID_SP]; end
      SRC_FRAME:  begin seg_sel = regs[RID_STK];   off_sel = regs[RID_BP]; end
      SRC_STRSRC: begin seg_sel = regs[RID_DATA];  off_sel = regs[RID_SI]; end
      SRC_STRDST: begin seg_sel = regs[RID_EXTRA]; off_sel = regs[RID_DI]; end
      default:    src_ok = 1'b0;
    endcase
    sum = {seg_sel, {SHIFT{1'b0}}} + ADDR_W'(off_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr       <= '0;
    end else begin
      addr_valid <= req_valid && src_ok;
      if (req_valid && src_ok) addr <= sum;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import sag_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_en,
  input  logic [SEL_W-1:0]       ld_sel,
  input  logic [SEG_W-1:0]       ld_data,
  input  logic                   step_en,
  input  logic [1:0]             step_size,
  input  logic                   dir_down,
  input  logic                   req_valid,
  input  logic [2:0]             req_src,
  output logic                   addr_valid,
  output logic [SEG_W+SHIFT-1:0] addr
);
  logic [NUM_REGS-1:0][SEG_W-1:0] regs;
  logic                           step_go;
  logic [SEG_W-1:0]               step_amt;

  assign step_go  = step_en && (step_size != 2'd3);
  assign step_amt = SEG_W'(1) << step_size;

  sag_regfile #(.W(SEG_W)) u_regs (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .step_go(step_go), .step_dec(dir_down), .step_amt(step_amt), .regs_o(regs)
  );

  sag_addr_calc #(.W(SEG_W), .SHIFT(SHIFT)) u_calc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .regs(regs), .addr_valid(addr_valid), .addr(addr)
  );
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ld_en,
  input logic [3:0]             ld_sel,
  input logic                   step_en,
  input logic [1:0]             step_size,
  input logic                   dir_down,
  input logic                   req_valid,
  input logic [2:0]             req_src,
  input logic                   addr_valid,
  input logic [SEG_W+SHIFT-1:0] addr,
  input logic [SEG_W-1:0]       cs,
  input logic [SEG_W-1:0]       ip,
  input logic [SEG_W-1:0]       si,
  input logic [SEG_W-1:0]       di
);
  localparam int ADDR_W = SEG_W + SHIFT;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_src <= 3'd4) |=> addr_valid); // R1

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_src > 3'd4) |=> !addr_valid); // R13

  AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_src == 3'd0) |=>
      addr == ({$past(cs), {SHIFT{1'b0}}} + ADDR_W'($past(ip)))); // R2

  AST_CODE_SEG_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cs == {SEG_W{1'b1}}); // R7

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_size != 2'd3 && !dir_down && !(ld_en && ld_sel == 4'd7)) |=>
      si == $past(si) + (SEG_W'(1) << $past(step_size))); // R9

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_size != 2'd3 && dir_down && !(ld_en && ld_sel == 4'd8)) |=>
      di == $past(di) - (SEG_W'(1) << $past(step_size))); // R10

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && (!step_en || step_size == 2'd3)) |=> ($stable(si) && $stable(di))); // R9
endmodule

bind seg_addr_gen sag_checker #(.SEG_W(SEG_W), .SHIFT(SHIFT)) u_sag_chk (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .step_en(step_en),
  .step_size(step_size), .dir_down(dir_down), .req_valid(req_valid),
  .req_src(req_src), .addr_valid(addr_valid), .addr(addr),
  .cs(regs[0]), .ip(regs[4]), .si(regs[7]), .di(regs[8])
);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        step_en = 1'b0;
  logic [1:0]  step_size = '0;
  logic        dir_down = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_src = '0;
  logic        addr_valid;
  logic [19:0] addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] m [9];
  logic [15:0] pats [8] = '{16'h0000, 16'h0001, 16'h000F, 16'h1234,
                            16'h8000, 16'hABCD, 16'hFFF0, 16'hFFFF};
  int seg_of [5] = '{0, 2, 2, 1, 3};
  int ptr_of [5] = '{4, 5, 6, 7, 8};

  always #5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .step_en(step_en), .step_size(step_size), .dir_down(dir_down),
    .req_valid(req_valid), .req_src(req_src), .addr_valid(addr_valid), .addr(addr)
  );

  initial begin
    #1_500_000;
    $display("FAIL watchdog expired");
    errors++;
    checks++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [19:0] exp_addr(int src);
    logic [19:0] a;
    a = {m[seg_of[src]], 4'h0} + {4'h0, m[ptr_of[src]]};
    return a;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(int id, logic [15:0] v);
    ld_en = 1'b1; ld_sel = 4'(id); ld_data = v;
    tick;
    ld_en = 1'b0;
    if (id < 9) m[id] = v;
  endtask

  task automatic req_check(int src, string tag);
    req_valid = 1'b1; req_src = 3'(src);
    tick;
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(addr_valid), 32'd1);
    chk(tag, 32'(addr), 32'(exp_addr(src)));
  endtask

  function automatic logic [15:0] stepped(logic [15:0] v, int sz, bit dn);
    logic [15:0] d;
    if (sz == 3) return v;
    d = 16'(1) << sz;
    return dn ? v - d : v + d;
  endfunction

  initial begin
    for (int i = 0; i < 9; i++) m[i] = 16'h0000;
    m[0] = 16'hFFFF;
    tick; tick;
    chk("R7 valid in reset", 32'(addr_valid), 32'd0);
    rst = 1'b0;
    tick;
    chk("R7 valid after reset", 32'(addr_valid), 32'd0);
    req_check(0, "R7 R2 fetch after reset");
    req_check(1, "R7 R3 stack after reset");
    req_check(4, "R7 R6 strdst after reset");

    // R1..R6 sweep over segment and pointer patterns
    for (int s = 0; s < 5; s++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          load(seg_of[s], pats[a]);
          load(ptr_of[s], pats[b]);
          case (s)
            0: req_check(s, "R1 R2 fetch");
            1: req_check(s, "R1 R3 stack");
            2: req_check(s, "R1 R4 frame");
            3: req_check(s, "R1 R5 strsrc");
            default: req_check(s, "R1 R6 strdst");
          endcase
        end

    // R13 unused source codes and idle
    for (int s = 5; s < 8; s++) begin
      req_valid = 1'b1; req_src = 3'(s);
      tick;
      req_valid = 1'b0;
      chk("R13 bad source", 32'(addr_valid), 32'd0);
    end
    tick;
    chk("R13 idle", 32'(addr_valid), 32'd0);

    // R8 distinct values, then unused select codes ignored
    for (int i = 0; i < 9; i++) load(i, 16'h1111 * 16'(i + 1));
    for (int c = 9; c < 16; c++) load(c, 16'hDEAD);
    for (int s = 0; s < 5; s++) req_check(s, "R8 load and unused codes");

    // R9 / R10 stepping
    load(1, 16'h0000);
    load(3, 16'h0000);
    for (int dn = 0; dn < 2; dn++)
      for (int sz = 0; sz < 4; sz++)
        for (int k = 0; k < 3; k++) begin
          logic [15:0] st;
          st = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFE : 16'h7FFF;
          load(7, st);
          load(8, st ^ 16'h00F0);
          step_en = 1'b1; step_size = 2'(sz); dir_down = dn[0];
          tick;
          step_en = 1'b0;
          m[7] = stepped(m[7], sz, dn[0]);
          m[8] = stepped(m[8], sz, dn[0]);
          req_check(3, dn ? "R10 si step down" : "R9 si step up");
          req_check(4, dn ? "R10 di step down" : "R9 di step up");
        end

    // R11 load wins over step, other index still steps
    load(7, 16'h0010);
    load(8, 16'h0020);
    step_en = 1'b1; step_size = 2'd1; dir_down = 1'b0;
    ld_en = 1'b1; ld_sel = 4'd7; ld_data = 16'h0500;
    tick;
    step_en = 1'b0; ld_en = 1'b0;
    m[7] = 16'h0500; m[8] = 16'h0022;
    req_check(3, "R11 loaded si");
    req_check(4, "R11 stepped di");

    // R12 request sees pre-load value
    load(2, 16'h0100);
    load(5, 16'h0020);
    req_valid = 1'b1; req_src = 3'd1;
    ld_en = 1'b1; ld_sel = 4'd5; ld_data = 16'h0040;
    tick;
    req_valid = 1'b0; ld_en = 1'b0;
    chk("R12 old value", 32'(addr), 32'h01020);
    m[5] = 16'h0040;
    req_check(1, "R12 new value");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule